// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block records a stream of 32-bit trace words into an on-chip circular RAM. While capture runs, every word presented with a valid strobe passes through a single staging register and is then written at the write pointer, which advances by one and wraps modulo the RAM depth. The depth is a power-of-two parameter fixed at build time. A sticky flag records that the write pointer has rolled over, so software knows the whole RAM holds valid history.

A trigger input arms a post-trigger counter. Once the trigger is seen, exactly the programmed count plus one further words reach the RAM and capture then stops on its own. Software can also stop capture by clearing the enable. Capture then ends as soon as the staged word has been written. When capture is stopped, software reads the RAM back through a read pointer and read-data register, or preloads it through the write pointer and write-data register. While capture is busy, that access is locked out.

The register port has eight word registers selected by a 3-bit address. Reads return data combinationally in the cycle in which the read strobe is high. Side effects take place at the clock edge that ends that cycle.

Top module: `trace_capture_buf`

## Requirements
- R1: The depth register (address 2) reads the RAM depth in words, which equals the DEPTH parameter.
- R2: The status register (address 1) carries wrapped in bit 0, triggered in bit 1, stopped in bit 2 and pipeline-empty in bit 3, and reads 0x8 from reset.
- R3: While capture runs, the write pointer (address 4) advances by one for each word written. Its step from DEPTH-1 to 0 sets the sticky wrapped bit.
- R4: After the trigger input is sampled high during capture, exactly trigger-count+1 more words are written, including a word presented in the trigger cycle. Capture then stops, and status reads triggered and stopped. A trigger count of 0 writes one word.
- R5: Capture is busy while the enable (bit 0 of address 0) is 1 and stopped is 0, or while a staged word is still pending. Writes to the read pointer (address 6), write pointer or trigger count (address 3) made while busy leave them unchanged.
- R6: While busy, reads of read-data (address 7) and write-data (address 5) return 0xFFFFFFFF. Such a read leaves the read pointer where it was, and a write-data write stores nothing and does not move the write pointer.
- R7: When not busy, writing the read pointer fetches the word at that address into read-data, ready in the next cycle. Each read of read-data returns the current word and then advances the pointer and fetches the next word, so back-to-back reads are possible.
- R8: When not busy, each write-data write stores the word at the write pointer and advances it. A read of write-data returns the last word written and leaves the write pointer unchanged.
- R9: Writing 0 to the enable while capture runs lets a staged word reach the RAM, which shows as pipeline-empty 0. Stopped then rises, with status reading 0x0, then 0x8, then 0xC in the three cycles after the write.
- R10: Writing 1 to the enable when capture is not running clears the wrapped, triggered and stopped bits and restarts capture at the current write pointer.
- R11: The read and write pointers wrap modulo DEPTH under software access as well.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (causes read-data side effects) |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| trc_valid | input | 1 | Trace word valid |
| trc_data | input | 32 | Trace word |
| trig_in | input | 1 | Trigger event |

## Verification
The bench builds the block with DEPTH set to 16. At that depth a single capture run of a few dozen words laps the RAM and sets the wrapped bit, and a software preload can start at entry 12 and wrap both pointers through zero. The small depth also means the words left from an earlier lap can be compared against the entry just past the stop point, which shows that capture wrote no extra word after the trigger count ran out.

// File: rtl/tcb_pkg.sv
package tcb_pkg;

  localparam int unsigned WORD_W = 32;

  // register select encoding of the 3-bit register address
  typedef enum logic [2:0] {
    SEL_CTRL   = 3'd0,
    SEL_STATUS = 3'd1,
    SEL_DEPTH  = 3'd2,
    SEL_TRIG   = 3'd3,
    SEL_WPTR   = 3'd4,
    SEL_WDATA  = 3'd5,
    SEL_RPTR   = 3'd6,
    SEL_RDATA  = 3'd7
  } reg_sel_e;

  // status word bit positions
  localparam int unsigned ST_WRAP  = 0;
  localparam int unsigned ST_TRIG  = 1;
  localparam int unsigned ST_STOP  = 2;
  localparam int unsigned ST_EMPTY = 3;
  localparam int unsigned ST_W     = 4;

endpackage

// File: rtl/tcb_ram.sv
module tcb_ram #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned W     = 32,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  // storage array: no reset, write port with explicit enable
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // synchronous read port, one cycle of latency, clock-enabled
  always_ff @(posedge clk) begin
    if (re) begin
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/tcb_capture.sv
module tcb_capture
  import tcb_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  // trace stream
  input  logic              trc_valid,
  input  logic [WORD_W-1:0] trc_data,
  input  logic              trig_in,
  // decoded register strobes
  input  logic              ctrl_wr,
  input  logic              ctrl_en,
  input  logic              trig_wr,
  input  logic              wptr_wr,
  input  logic              wdat_wr,
  input  logic [AW-1:0]     load_val,
  input  logic [WORD_W-1:0] sw_word,
  // RAM write port
  output logic              ram_we,
  output logic [AW-1:0]     ram_waddr,
  output logic [WORD_W-1:0] ram_wdata,
  // state seen by the register port
  output logic              busy,
  output logic              en,
  output logic [AW-1:0]     wptr,
  output logic [AW-1:0]     tcnt,
  output logic [ST_W-1:0]   status
);

  localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);

  logic              en_q, en_d;
  logic              stopped_q, stopped_d;
  logic              draining_q, draining_d;
  logic              full_q, full_d;
  logic              trig_q, trig_d;
  logic              armed_q, armed_d;
  logic [AW-1:0]     remain_q, remain_d;
  logic [AW-1:0]     tcnt_q, tcnt_d;
  logic [AW-1:0]     wptr_q, wptr_d;
  logic              pend_vld_q, pend_vld_d;
  logic [WORD_W-1:0] pend_data_q;
  logic              pend_load;

  logic active, restart, drain_start, cap_we, sw_we, stop_now, trig_hit;

  always_comb begin
    active      = en_q & ~stopped_q;
    busy        = active | pend_vld_q;
    restart     = ctrl_wr & ctrl_en & ~active;
    drain_start = ctrl_wr & ~ctrl_en & en_q;
    cap_we      = pend_vld_q;
    sw_we       = wdat_wr & ~busy;
    stop_now    = cap_we & armed_q & (remain_q == '0);
    trig_hit    = active & trig_in & ~trig_q;
    pend_load   = active & trc_valid & ~stop_now;
  end

  // next-state logic
  always_comb begin
    en_d       = ctrl_wr ? ctrl_en : en_q;

    stopped_d  = stopped_q;
    if (restart) begin
      stopped_d = 1'b0;
    end else if (stop_now || (draining_q && !pend_vld_q)) begin
      stopped_d = 1'b1;
    end

    draining_d = draining_q;
    if (restart) begin
      draining_d = 1'b0;
    end else if (drain_start) begin
      draining_d = 1'b1;
    end else if (draining_q && !pend_vld_q) begin
      draining_d = 1'b0;
    end

    full_d = full_q;
    if (restart) begin
      full_d = 1'b0;
    end else if (cap_we && (wptr_q == PTR_MAX)) begin
      full_d = 1'b1;
    end

    trig_d = trig_q;
    if (restart) begin
      trig_d = 1'b0;
    end else if (trig_hit) begin
      trig_d = 1'b1;
    end

    armed_d  = armed_q;
    remain_d = remain_q;
    if (restart) begin
      armed_d = 1'b0;
    end else if (trig_hit) begin
      armed_d  = 1'b1;
      remain_d = tcnt_q;
    end else if (stop_now) begin
      armed_d = 1'b0;
    end else if (cap_we && armed_q) begin
      remain_d = remain_q - 1'b1;
    end

    tcnt_d = (trig_wr && !busy) ? load_val : tcnt_q;

    wptr_d = wptr_q;
    if (wptr_wr && !busy) begin
      wptr_d = load_val;
    end else if (cap_we || sw_we) begin
      wptr_d = wptr_q + 1'b1;
    end

    pend_vld_d = pend_load;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      stopped_q  <= 1'b0;
      draining_q <= 1'b0;
      full_q     <= 1'b0;
      trig_q     <= 1'b0;
      armed_q    <= 1'b0;
      remain_q   <= '0;
      tcnt_q     <= '0;
      wptr_q     <= '0;
      pend_vld_q <= 1'b0;
    end else begin
      en_q       <= en_d;
      stopped_q  <= stopped_d;
      draining_q <= draining_d;
      full_q     <= full_d;
      trig_q     <= trig_d;
      armed_q    <= armed_d;
      remain_q   <= remain_d;
      tcnt_q     <= tcnt_d;
      wptr_q     <= wptr_d;
      pend_vld_q <= pend_vld_d;
    end
  end

  // staging data register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_data_q <= '0;
    end else if (pend_load) begin
      pend_data_q <= trc_data;
    end
  end

  always_comb begin
    ram_we    = cap_we | sw_we;
    ram_waddr = wptr_q;
    ram_wdata = cap_we ? pend_data_q : sw_word;
    en        = en_q;
    wptr      = wptr_q;
    tcnt      = tcnt_q;
    status           = '0;
    status[ST_WRAP]  = full_q;
    status[ST_TRIG]  = trig_q;
    status[ST_STOP]  = stopped_q;
    status[ST_EMPTY] = ~pend_vld_q;
  end

  // each RAM write not overridden by a pointer load moves the pointer by one
  assert_wptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !(wptr_wr && !busy)) |=> (wptr_q == AW'($past(wptr_q) + 1'b1)));

  // wrapped flag only falls on a restart
  assert_full_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !restart) |=> full_q);

  // with the enable still set, only a completed trigger count stops capture
  assert_trig_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stopped_q) && en_q) |-> trig_q);

  // nothing is left staged once capture has stopped
  assert_idle_when_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stopped_q |-> !pend_vld_q);

  // restart leaves all sticky status clear
  assert_restart_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!full_q && !trig_q && !stopped_q));

endmodule

// File: rtl/tcb_regport.sv
module tcb_regport
  import tcb_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  // capture core interface
  input  logic              busy,
  input  logic              en,
  input  logic [AW-1:0]     wptr,
  input  logic [AW-1:0]     tcnt,
  input  logic [ST_W-1:0]   status,
  output logic              ctrl_wr,
  output logic              ctrl_en,
  output logic              trig_wr,
  output logic              wptr_wr,
  output logic              wdat_wr,
  output logic [AW-1:0]     load_val,
  // RAM read port
  output logic              ram_re,
  output logic [AW-1:0]     ram_raddr,
  input  logic [WORD_W-1:0] ram_rdata
);

  localparam logic [WORD_W-1:0] ALL_ONES = '1;
  localparam int unsigned       PAD_W    = WORD_W - AW;

  reg_sel_e          sel;
  logic [AW-1:0]     rptr_q, rptr_d;
  logic [WORD_W-1:0] wshadow_q;
  logic              rptr_wr, rdat_rd, shadow_load;

  always_comb begin
    sel         = reg_sel_e'(reg_addr);
    ctrl_wr     = reg_wr & (sel == SEL_CTRL);
    ctrl_en     = reg_wdata[0];
    trig_wr     = reg_wr & (sel == SEL_TRIG);
    wptr_wr     = reg_wr & (sel == SEL_WPTR);
    wdat_wr     = reg_wr & (sel == SEL_WDATA);
    rptr_wr     = reg_wr & (sel == SEL_RPTR);
    rdat_rd     = reg_rd & (sel == SEL_RDATA);
    load_val    = reg_wdata[AW-1:0];
    shadow_load = wdat_wr & ~busy;
  end

  // read pointer next state; the RAM is addressed with it so the fetched
  // word lines up with the pointer after the same edge
  always_comb begin
    rptr_d = rptr_q;
    if (rptr_wr && !busy) begin
      rptr_d = reg_wdata[AW-1:0];
    end else if (rdat_rd && !busy) begin
      rptr_d = rptr_q + 1'b1;
    end
    ram_re    = ~busy;
    ram_raddr = rptr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
    end else begin
      rptr_q <= rptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wshadow_q <= '0;
    end else if (shadow_load) begin
      wshadow_q <= reg_wdata;
    end
  end

  // read multiplexer
  always_comb begin
    unique case (sel)
      SEL_CTRL:   reg_rdata = {{(WORD_W-1){1'b0}}, en};
      SEL_STATUS: reg_rdata = {{(WORD_W-ST_W){1'b0}}, status};
      SEL_DEPTH:  reg_rdata = WORD_W'(DEPTH);
      SEL_TRIG:   reg_rdata = {{PAD_W{1'b0}}, tcnt};
      SEL_WPTR:   reg_rdata = {{PAD_W{1'b0}}, wptr};
      SEL_WDATA:  reg_rdata = busy ? ALL_ONES : wshadow_q;
      SEL_RPTR:   reg_rdata = {{PAD_W{1'b0}}, rptr_q};
      SEL_RDATA:  reg_rdata = busy ? ALL_ONES : ram_rdata;
      default:    reg_rdata = '0;
    endcase
  end

  // the read pointer never moves while capture is busy
  assert_rptr_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (rptr_q == $past(rptr_q)));

  // locked-out RAM data reads give all ones
  assert_lockout_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (reg_addr == 3'd7)) |-> (reg_rdata == ALL_ONES));

  // an accepted read of read-data advances the pointer by one
  assert_read_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdat_rd && !busy) |=> (rptr_q == AW'($past(rptr_q) + 1'b1)));

endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
  import tcb_pkg::*;
#(
  parameter int unsigned DEPTH = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              trc_valid,
  input  logic [WORD_W-1:0] trc_data,
  input  logic              trig_in
);

  localparam int unsigned AW = $clog2(DEPTH);

  // asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic              busy, en;
  logic [AW-1:0]     wptr, tcnt, load_val;
  logic [ST_W-1:0]   status;
  logic              ctrl_wr, ctrl_en, trig_wr, wptr_wr, wdat_wr;
  logic              ram_we, ram_re;
  logic [AW-1:0]     ram_waddr, ram_raddr;
  logic [WORD_W-1:0] ram_wdata, ram_rdata;

  tcb_capture #(.DEPTH(DEPTH), .AW(AW)) i_capture (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .trc_valid (trc_valid),
    .trc_data  (trc_data),
    .trig_in   (trig_in),
    .ctrl_wr   (ctrl_wr),
    .ctrl_en   (ctrl_en),
    .trig_wr   (trig_wr),
    .wptr_wr   (wptr_wr),
    .wdat_wr   (wdat_wr),
    .load_val  (load_val),
    .sw_word   (reg_wdata),
    .ram_we    (ram_we),
    .ram_waddr (ram_waddr),
    .ram_wdata (ram_wdata),
    .busy      (busy),
    .en        (en),
    .wptr      (wptr),
    .tcnt      (tcnt),
    .status    (status)
  );

  tcb_regport #(.DEPTH(DEPTH), .AW(AW)) i_regport (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .en        (en),
    .wptr      (wptr),
    .tcnt      (tcnt),
    .status    (status),
    .ctrl_wr   (ctrl_wr),
    .ctrl_en   (ctrl_en),
    .trig_wr   (trig_wr),
    .wptr_wr   (wptr_wr),
    .wdat_wr   (wdat_wr),
    .load_val  (load_val),
    .ram_re    (ram_re),
    .ram_raddr (ram_raddr),
    .ram_rdata (ram_rdata)
  );

  tcb_ram #(.DEPTH(DEPTH), .W(WORD_W), .AW(AW)) i_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

endmodule

// File: tb/test_trace_capture_buf.sv
`timescale 1ns/1ps
module test_trace_capture_buf;

  localparam int unsigned DEPTH = 16;
  localparam logic [2:0] A_CTRL = 3'd0, A_STATUS = 3'd1, A_DEPTH = 3'd2,
                         A_TRIG = 3'd3, A_WPTR = 3'd4, A_WDATA = 3'd5,
                         A_RPTR = 3'd6, A_RDATA = 3'd7;

  // preload vectors: words written from entry 12 onward, read back in order
  localparam int unsigned NVEC = 8;
  localparam logic [31:0] PRELOAD [NVEC] = '{
    32'hA5A5_0001, 32'h5A5A_0002, 32'hFFFF_0000, 32'h0000_FFFF,
    32'h1234_5678, 32'h8765_4321, 32'h0000_0000, 32'hCAFE_F00D
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        trc_valid, trig_in;
  logic [31:0] trc_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  trace_capture_buf #(.DEPTH(DEPTH)) i_trace_capture_buf (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .trc_valid(trc_valid), .trc_data(trc_data), .trig_in(trig_in)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic stream(input int n, input int trig_at, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      trc_valid = 1'b1;
      trc_data  = base + 32'(i);
      trig_in   = (i == trig_at);
      @(negedge clk);
    end
    trc_valid = 1'b0;
    trig_in   = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = A_STATUS;
    reg_wdata = '0; trc_valid = 1'b0; trc_data = '0; trig_in = 1'b0;
    repeat (3) @(negedge clk);
    #1 chk("R2 status during reset", reg_rdata, 32'h8);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    rd(A_STATUS, v); chk("R2 status after reset", v, 32'h8);
    rd(A_DEPTH, v);  chk("R1 depth", v, DEPTH);
    rd(A_WPTR, v);   chk("R3 write pointer reset", v, 32'd0);

    // preload across the top of the RAM, then walk the vectors back
    wr(A_WPTR, 32'd12);
    for (int i = 0; i < NVEC; i++) wr(A_WDATA, PRELOAD[i]);
    rd(A_WPTR, v);  chk("R11 write pointer wrapped", v, 32'd4);
    rd(A_WDATA, v); chk("R8 write-data readback", v, PRELOAD[NVEC-1]);
    rd(A_WPTR, v);  chk("R8 write-data read leaves pointer", v, 32'd4);
    wr(A_RPTR, 32'd12);
    for (int i = 0; i < NVEC; i++) begin
      rd(A_RPTR, v);  chk("R11 read pointer walk", v, 32'((12 + i) % DEPTH));
      rd(A_RDATA, v); chk("R7 read-data stream", v, PRELOAD[i]);
    end

    // start capture and probe the lockout
    wr(A_TRIG, 32'd3);
    wr(A_WPTR, 32'd0);
    wr(A_CTRL, 32'd1);
    rd(A_RDATA, v); chk("R6 read-data locked", v, 32'hFFFF_FFFF);
    rd(A_RPTR, v);  chk("R6 read pointer held", v, 32'd4);
    rd(A_WDATA, v); chk("R6 write-data locked", v, 32'hFFFF_FFFF);
    wr(A_WDATA, 32'hDEAD_BEEF);
    rd(A_WPTR, v);  chk("R6 write-data write discarded", v, 32'd0);
    wr(A_RPTR, 32'd5);
    rd(A_RPTR, v);  chk("R5 read pointer write ignored", v, 32'd4);
    wr(A_WPTR, 32'd9);
    rd(A_WPTR, v);  chk("R5 write pointer write ignored", v, 32'd0);
    wr(A_TRIG, 32'd7);
    rd(A_TRIG, v);  chk("R5 trigger count write ignored", v, 32'd3);

    // 30 words, trigger with word 18: words 0..21 stored, pointer ends at 22 mod 16
    stream(30, 18, 32'h100);
    rd(A_WPTR, v);   chk("R4 stop after count+1 words", v, 32'd6);
    rd(A_STATUS, v); chk("R3 R4 wrapped triggered stopped", v, 32'hF);
    wr(A_RPTR, 32'd5);
    rd(A_RDATA, v);  chk("R4 last counted word", v, 32'h115);
    rd(A_RDATA, v);  chk("R4 no word beyond count", v, 32'h106);

    // restart clears sticky status
    wr(A_CTRL, 32'd1);
    rd(A_STATUS, v); chk("R10 restart clears status", v, 32'h8);

    // disable with a word in flight
    reg_addr = A_CTRL; reg_wdata = 32'd0; reg_wr = 1'b1;
    trc_valid = 1'b1; trc_data = 32'h0000_ABCD;
    @(negedge clk);
    reg_wr = 1'b0; trc_valid = 1'b0; reg_addr = A_STATUS;
    #1 chk("R9 word pending", reg_rdata, 32'h0);
    @(negedge clk);
    #1 chk("R9 pending drained", reg_rdata, 32'h8);
    @(negedge clk);
    #1 chk("R9 stopped after drain", reg_rdata, 32'hC);
    @(negedge clk);
    rd(A_WPTR, v);  chk("R9 drained word advanced pointer", v, 32'd7);
    wr(A_RPTR, 32'd6);
    rd(A_RDATA, v); chk("R9 drained word stored", v, 32'h0000_ABCD);

    // zero trigger count: trigger word alone is stored
    wr(A_TRIG, 32'd0);
    wr(A_WPTR, 32'd0);
    wr(A_CTRL, 32'd1);
    stream(4, 1, 32'h200);
    rd(A_WPTR, v);   chk("R4 zero count pointer", v, 32'd2);
    rd(A_STATUS, v); chk("R4 zero count status", v, 32'hE);
    wr(A_RPTR, 32'd1);
    rd(A_RDATA, v);  chk("R4 zero count trigger word", v, 32'h201);
    rd(A_RDATA, v);  chk("R4 zero count nothing after", v, 32'h112);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule